// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block is a system-management watchdog that software controls through a small 16-bit register bus. A down-counter, advanced by a single-cycle tick enable, is loaded from a programmable start value. If software fails to service it in time, the counter expires. The first expiry records a timeout flag and may raise a one-cycle interrupt request toward the management handler. The counter then restarts on its own. If it expires a second time with no software reload in between, the block records a second-timeout flag and raises a one-cycle platform reset request. A no-reboot setting can suppress that reset request.

Software services the watchdog by writing the reload register. It halts or runs the counter with a halt bit. It clears status flags by writing ones to them. The second-timeout and boot flags survive the system reset and are cleared only by the power-on reset, so firmware can tell after a restart that the watchdog caused it. The parameter `WIDE` selects the register layout. The wide layout has a 16-bit start count. The narrow layout has an 8-bit start count and uses only the low byte of writes to it.

Register map, by word address. Register 0 is control: bit 0 is halt, bit 9 is a sticky lock. Register 1 is the start count. Register 2 is reload. Register 3 is the live count, read-only. Register 4 is status A: bit 0 is the timeout flag. Register 5 is status B: bit 1 is the second-timeout flag and bit 2 is the boot flag. Register 6 is the interrupt enable, bit 0. Register 7 is no-reboot, bit 0.

Top module: `escal_wdog`

## Requirements
- R1: After power-on reset the registers read as follows. Control reads 0x0001 (halted). Start count and live count read 4. Status A reads 0. Status B reads 0x0004 (boot flag set). Interrupt enable reads 1. No-reboot reads the `strap_noreboot` input. Both request outputs are 0.
- R2: The live count (register 3) drops by one on each cycle where `tick` is 1 and halt is 0. While halt is 1, ticks leave the count unchanged.
- R3: In control, bit 0 (halt) is read/write. Writing 1 to bit 9 sets it, and it then stays set through any later write until a reset. All other control bits read 0.
- R4: A write to the start count (register 1) stores the value, raising anything below 2 to 2. The live count does not change until the next reload.
- R5: A write to register 2 with any of data bits 4..0 set reloads the live count from the start count and cancels a pending second stage. A write with those five bits all 0 has no effect. Register 2 reads 0.
- R6: When the count expires (a tick while it is 1) with no stage pending, status A bit 0 is set, the count reloads and the second stage is armed. In the same cycle `smi_req` pulses for one cycle if interrupt enable bit 0 is 1.
- R7: An expiry while the second stage is armed sets status B bit 1. It pulses `rst_req` for exactly one cycle if no-reboot is 0, reloads the count and disarms the second stage. `smi_req` and `rst_req` are never high together.
- R8: Status A bit 0 and status B bits 1 and 2 clear only when a 1 is written to them; a 0 leaves them unchanged. A single write carrying both bit 1 and bit 2 clears only bit 1.
- R9: Driving `rst_n` low resets every register to its R1 value except status B bits 1 and 2, which keep their values. Driving `por_n` low clears bit 1 and sets bit 2.
- R10: No-reboot bit 0 reloads from `strap_noreboot` on either reset. Writing 1 sets it. Writing 0 clears it only while control bit 9 is 0, so software must read it back to confirm the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous system reset, active low; keeps status B |
| tick | input | 1 | Single-cycle count enable |
| strap_noreboot | input | 1 | Reset value of the no-reboot bit |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| smi_req | output | 1 | One-cycle first-stage interrupt request |
| rst_req | output | 1 | One-cycle second-stage reset request |

## Verification
A table of start-count writes covers the values 0, 1 and 2 (all raised to the minimum), 3, a mid-range value and the full-scale value. Each entry also checks that the live count stays put until a reload. Expiry is exercised four ways: back-to-back expiries, expiries with a software reload between them, the interrupt enable off, and no-reboot set. Between them these separate the first stage from the second, show that a reload cancels arming, and show that each gate acts only on its own request. Reload writes with only bit 5 or only high bits set are contrasted with a bit-4 write. Status writes with 0, with both status B bits, and then with the remaining bit show write-one-to-clear and its priority. The two resets are compared, and the locked and unlocked clears of no-reboot are read back.

// File: rtl/escal_wdog_pkg.sv
package escal_wdog_pkg;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_INIT   = 3'd1,
        A_RELOAD = 3'd2,
        A_COUNT  = 3'd3,
        A_STSA   = 3'd4,
        A_STSB   = 3'd5,
        A_SMICFG = 3'd6,
        A_NORB   = 3'd7
    } wd_addr_e;

    localparam int HALT_BIT   = 0;
    localparam int KEEP_BIT   = 9;
    localparam int TO_BIT     = 0;
    localparam int ST2_BIT    = 1;
    localparam int BOOT_BIT   = 2;
    localparam int RLD_BITS   = 5;
    localparam int MIN_INIT   = 2;
    localparam int RST_INIT   = 4;
    localparam int BUS_W      = 16;

endpackage

// File: rtl/escal_wdog_cnt.sv
module escal_wdog_cnt
    import escal_wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             reload,
    input  logic [CNT_W-1:0] init,
    input  logic             smi_en,
    input  logic             noreboot,
    output logic [CNT_W-1:0] cnt,
    output logic             exp_first,
    output logic             exp_second,
    output logic             smi_req,
    output logic             rst_req
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             smi;
        logic             rst;
    } cnt_st_t;

    localparam cnt_st_t RST_ST = '{cnt: CNT_W'(RST_INIT), armed: 1'b0, smi: 1'b0, rst: 1'b0};

    cnt_st_t st_d, st_q;
    logic    expire;

    always_comb begin
        st_d     = st_q;
        st_d.smi = 1'b0;
        st_d.rst = 1'b0;
        expire   = tick && !halt && !reload && (st_q.cnt <= CNT_W'(1));

        if (reload) begin
            st_d.cnt   = init;
            st_d.armed = 1'b0;
        end else if (tick && !halt) begin
            if (expire) begin
                st_d.cnt   = init;
                st_d.armed = !st_q.armed;
                st_d.smi   = !st_q.armed && smi_en;
                st_d.rst   = st_q.armed && !noreboot;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        if (!rst_n) begin
            st_d = RST_ST;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign cnt        = st_q.cnt;
    assign exp_first  = expire && !st_q.armed && rst_n;
    assign exp_second = expire && st_q.armed && rst_n;
    assign smi_req    = st_q.smi;
    assign rst_req    = st_q.rst;

endmodule

// File: rtl/escal_wdog_regs.sv
module escal_wdog_regs
    import escal_wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             strap_noreboot,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             exp_first,
    input  logic             exp_second,
    input  logic [CNT_W-1:0] cnt,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             halt,
    output logic             reload,
    output logic [CNT_W-1:0] init,
    output logic             smi_en,
    output logic             noreboot
);

    typedef struct packed {
        logic             halt;
        logic             keep;
        logic [CNT_W-1:0] init;
        logic             to_flag;
        logic             st2;
        logic             boot;
        logic             smi_en;
        logic             norb;
    } reg_st_t;

    reg_st_t          rg_d, rg_q;
    wd_addr_e         addr;
    logic [CNT_W-1:0] init_wr;

    assign addr    = wd_addr_e'(bus_addr);
    assign init_wr = bus_wdata[CNT_W-1:0];
    assign reload  = bus_we && (addr == A_RELOAD) && (|bus_wdata[RLD_BITS-1:0]);

    always_comb begin
        rg_d = rg_q;
        if (bus_we) begin
            case (addr)
                A_CTRL: begin
                    rg_d.halt = bus_wdata[HALT_BIT];
                    if (bus_wdata[KEEP_BIT]) rg_d.keep = 1'b1;
                end
                A_INIT: begin
                    rg_d.init = (init_wr < CNT_W'(MIN_INIT)) ? CNT_W'(MIN_INIT) : init_wr;
                end
                A_STSA: begin
                    if (bus_wdata[TO_BIT]) rg_d.to_flag = 1'b0;
                end
                A_STSB: begin
                    if (bus_wdata[ST2_BIT])       rg_d.st2  = 1'b0;
                    else if (bus_wdata[BOOT_BIT]) rg_d.boot = 1'b0;
                end
                A_SMICFG: rg_d.smi_en = bus_wdata[0];
                A_NORB: begin
                    if (bus_wdata[0])    rg_d.norb = 1'b1;
                    else if (!rg_q.keep) rg_d.norb = 1'b0;
                end
                default: ;
            endcase
        end

        if (exp_first)  rg_d.to_flag = 1'b1;
        if (exp_second) rg_d.st2     = 1'b1;

        if (!rst_n) begin
            rg_d.halt    = 1'b1;
            rg_d.keep    = 1'b0;
            rg_d.init    = CNT_W'(RST_INIT);
            rg_d.to_flag = 1'b0;
            rg_d.smi_en  = 1'b1;
            rg_d.norb    = strap_noreboot;
            rg_d.st2     = rg_q.st2;
            rg_d.boot    = rg_q.boot;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rg_q.halt    <= 1'b1;
            rg_q.keep    <= 1'b0;
            rg_q.init    <= CNT_W'(RST_INIT);
            rg_q.to_flag <= 1'b0;
            rg_q.st2     <= 1'b0;
            rg_q.boot    <= 1'b1;
            rg_q.smi_en  <= 1'b1;
            rg_q.norb    <= strap_noreboot;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (addr)
            A_CTRL: begin
                bus_rdata[HALT_BIT] = rg_q.halt;
                bus_rdata[KEEP_BIT] = rg_q.keep;
            end
            A_INIT:   bus_rdata[CNT_W-1:0] = rg_q.init;
            A_COUNT:  bus_rdata[CNT_W-1:0] = cnt;
            A_STSA:   bus_rdata[TO_BIT]    = rg_q.to_flag;
            A_STSB: begin
                bus_rdata[ST2_BIT]  = rg_q.st2;
                bus_rdata[BOOT_BIT] = rg_q.boot;
            end
            A_SMICFG: bus_rdata[0] = rg_q.smi_en;
            A_NORB:   bus_rdata[0] = rg_q.norb;
            default:  bus_rdata = '0;
        endcase
    end

    assign halt     = rg_q.halt;
    assign init     = rg_q.init;
    assign smi_en   = rg_q.smi_en;
    assign noreboot = rg_q.norb;

endmodule

// File: rtl/escal_wdog.sv
module escal_wdog
    import escal_wdog_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        strap_noreboot,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        smi_req,
    output logic        rst_req
);

    localparam int CNT_W = WIDE ? 16 : 8;

    logic             halt;
    logic             reload;
    logic [CNT_W-1:0] init;
    logic [CNT_W-1:0] cnt;
    logic             smi_en;
    logic             noreboot;
    logic             exp_first;
    logic             exp_second;

    escal_wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk            (clk),
        .por_n          (por_n),
        .rst_n          (rst_n),
        .strap_noreboot (strap_noreboot),
        .bus_we         (bus_we),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .exp_first      (exp_first),
        .exp_second     (exp_second),
        .cnt            (cnt),
        .bus_rdata      (bus_rdata),
        .halt           (halt),
        .reload         (reload),
        .init           (init),
        .smi_en         (smi_en),
        .noreboot       (noreboot)
    );

    escal_wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .tick       (tick),
        .halt       (halt),
        .reload     (reload),
        .init       (init),
        .smi_en     (smi_en),
        .noreboot   (noreboot),
        .cnt        (cnt),
        .exp_first  (exp_first),
        .exp_second (exp_second),
        .smi_req    (smi_req),
        .rst_req    (rst_req)
    );

endmodule

// File: rtl/escal_wdog_chk.sv
module escal_wdog_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_n,
    input logic             halt,
    input logic             reload,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] init,
    input logic             smi_en,
    input logic             noreboot,
    input logic             smi_req,
    input logic             rst_req
);

    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (halt && !reload) |=> $stable(cnt));

    assert_reload_load_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        reload |=> (cnt == $past(init)));

    assert_smi_gated_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        smi_req |-> $past(smi_en));

    assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        rst_req |=> !rst_req);

    assert_req_excl_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !(smi_req && rst_req));

    assert_norb_block_R10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        rst_req |-> !$past(noreboot));

endmodule

bind escal_wdog escal_wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .rst_n    (rst_n),
    .halt     (halt),
    .reload   (reload),
    .cnt      (cnt),
    .init     (init),
    .smi_en   (smi_en),
    .noreboot (noreboot),
    .smi_req  (smi_req),
    .rst_req  (rst_req)
);

// File: tb/escal_wdog_tb.sv
`timescale 1ns/100ps
module escal_wdog_tb;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        strap_noreboot = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        smi_req;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int smi_cnt = 0;
    int rst_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    escal_wdog u_dut (
        .clk            (clk),
        .por_n          (por_n),
        .rst_n          (rst_n),
        .tick           (tick),
        .strap_noreboot (strap_noreboot),
        .bus_we         (bus_we),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .smi_req        (smi_req),
        .rst_req        (rst_req)
    );

    always @(negedge clk) begin
        if (smi_req) smi_cnt++;
        if (rst_req) rst_cnt++;
    end

    localparam logic [31:0] INIT_VEC [6] = '{
        {16'h0000, 16'h0002}, {16'h0001, 16'h0002}, {16'h0002, 16'h0002},
        {16'h0003, 16'h0003}, {16'h0100, 16'h0100}, {16'hFFFF, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    // n ticks; samples both requests after the last tick's edge and one cycle later
    task automatic ticks_probe(input int n, output logic s0, output logic r0,
                               output logic s1, output logic r1);
        ticks(n - 1);
        @(negedge clk); tick = 1'b1;
        @(posedge clk); #1; s0 = smi_req; r0 = rst_req;
        @(negedge clk); tick = 1'b0;
        @(posedge clk); #1; s1 = smi_req; r1 = rst_req;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (all requirements) actual=hang expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic s0, r0, s1, r1;
        int base;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 ctrl", 3'd0, 16'h0001);
        rd_chk("R1 init", 3'd1, 16'd4);
        rd_chk("R1 count", 3'd3, 16'd4);
        rd_chk("R1 stsA", 3'd4, 16'h0000);
        rd_chk("R1 stsB", 3'd5, 16'h0004);
        rd_chk("R1 smicfg", 3'd6, 16'h0001);
        rd_chk("R1 norb", 3'd7, 16'h0000);
        rd_chk("R5 reload reads 0", 3'd2, 16'h0000);
        chk("R1 smi_req", {15'd0, smi_req}, 16'd0);
        chk("R1 rst_req", {15'd0, rst_req}, 16'd0);

        // R2 halted: ticks ignored
        ticks(3);
        rd_chk("R2 halted count", 3'd3, 16'd4);

        // R4 start-count table: clamp and no effect on live count
        foreach (INIT_VEC[i]) begin
            wr(3'd1, INIT_VEC[i][31:16]);
            rd_chk("R4 init clamp", 3'd1, INIT_VEC[i][15:0]);
            rd_chk("R4 count unchanged", 3'd3, 16'd4);
        end

        // R5 reload decode
        wr(3'd1, 16'd5);
        wr(3'd2, 16'h0020);
        rd_chk("R5 bit5 ignored", 3'd3, 16'd4);
        wr(3'd2, 16'hFFE0);
        rd_chk("R5 high bits ignored", 3'd3, 16'd4);
        wr(3'd2, 16'h0010);
        rd_chk("R5 bit4 reloads", 3'd3, 16'd5);

        // R3 control register
        wr(3'd0, 16'hFFFE);
        rd_chk("R3 only halt and bit9", 3'd0, 16'h0200);
        wr(3'd0, 16'h0000);
        rd_chk("R3 bit9 sticky", 3'd0, 16'h0200);

        // R2 running count, R6 first expiry
        ticks(2);
        rd_chk("R2 running count", 3'd3, 16'd3);
        ticks_probe(3, s0, r0, s1, r1);
        chk("R6 smi pulse", {14'd0, s0, r0}, 16'b10);
        chk("R6 smi one cycle", {14'd0, s1, r1}, 16'b00);
        rd_chk("R6 timeout flag", 3'd4, 16'h0001);
        rd_chk("R6 auto reload", 3'd3, 16'd5);

        // R8 status A write-one-to-clear
        wr(3'd4, 16'h0000);
        rd_chk("R8 write 0 keeps", 3'd4, 16'h0001);
        wr(3'd4, 16'h0001);
        rd_chk("R8 write 1 clears", 3'd4, 16'h0000);

        // R7 second expiry
        ticks_probe(5, s0, r0, s1, r1);
        chk("R7 rst pulse", {14'd0, s0, r0}, 16'b01);
        chk("R7 rst one cycle", {14'd0, s1, r1}, 16'b00);
        rd_chk("R7 second flag", 3'd5, 16'h0006);

        // R9 system reset keeps status B
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R9 stsB kept", 3'd5, 16'h0006);
        rd_chk("R9 ctrl reset", 3'd0, 16'h0001);
        rd_chk("R9 init reset", 3'd1, 16'd4);
        rd_chk("R9 count reset", 3'd3, 16'd4);

        // R8 status B priority
        wr(3'd5, 16'h0000);
        rd_chk("R8 stsB write 0", 3'd5, 16'h0006);
        wr(3'd5, 16'h0006);
        rd_chk("R8 lower bit first", 3'd5, 16'h0004);
        wr(3'd5, 16'h0004);
        rd_chk("R8 boot cleared", 3'd5, 16'h0000);

        // R5 reload cancels second stage
        wr(3'd0, 16'h0000);
        ticks_probe(4, s0, r0, s1, r1);
        chk("R6 smi after run", {14'd0, s0, r0}, 16'b10);
        wr(3'd2, 16'h0001);
        ticks_probe(4, s0, r0, s1, r1);
        chk("R5 disarmed, smi not rst", {14'd0, s0, r0}, 16'b10);
        rd_chk("R5 no second flag", 3'd5, 16'h0000);

        // R10 no-reboot suppresses reset request
        wr(3'd7, 16'h0001);
        rd_chk("R10 norb set", 3'd7, 16'h0001);
        base = rst_cnt;
        ticks_probe(4, s0, r0, s1, r1);
        @(negedge clk);
        chk("R10 no rst pulse", 16'(rst_cnt - base), 16'd0);
        rd_chk("R7 flag set under norb", 3'd5, 16'h0002);

        // R6 interrupt enable off
        wr(3'd6, 16'h0000);
        rd_chk("R6 smicfg off", 3'd6, 16'h0000);
        wr(3'd4, 16'h0001);
        base = smi_cnt;
        ticks_probe(4, s0, r0, s1, r1);
        @(negedge clk);
        chk("R6 gated smi", 16'(smi_cnt - base), 16'd0);
        rd_chk("R6 flag without smi", 3'd4, 16'h0001);

        // R10 lock blocks clear
        wr(3'd0, 16'h0200);
        wr(3'd7, 16'h0000);
        rd_chk("R10 locked clear refused", 3'd7, 16'h0001);

        // R9 power-on reset; R10 strap
        strap_noreboot = 1'b1;
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd_chk("R9 por stsB", 3'd5, 16'h0004);
        rd_chk("R10 strap loaded", 3'd7, 16'h0001);
        rd_chk("R9 por ctrl", 3'd0, 16'h0001);
        wr(3'd7, 16'h0000);
        rd_chk("R10 unlocked clear", 3'd7, 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule